// File: doc/BRIEF.md
# Baud Rate Pulse Meter

The block watches a serial receive line and gathers timing figures from which software can estimate the line rate. The raw line is first brought into the local clock domain by a flop chain. While measurement is switched on, the block times every run of constant level in clock cycles. It keeps the narrowest low run and the narrowest high run it has seen, counts the edges it accepts, and records the spacing between the two most recent rising edges and between the two most recent falling edges.

A programmable glitch width rejects short disturbances. When a run ends and it is narrower than the glitch width, the edge that ends it is not counted. That run also updates neither minimum, and that edge does not mark a period. Turning measurement on, or pulsing the clear input, starts a fresh measurement. The run that is in progress at that moment is only partly seen, so it never enters a minimum. All counters saturate and never wrap.

Top module: `baud_meter`

## Requirements
- R1: While measEn is 0 and clearIn is 0, all five result outputs hold their values, whatever the line does.
- R2: A run of constant level whose length is smaller than glitchWidth cycles is rejected. The edge that ends it does not increment edgeCount, does not update minLow or minHigh, and does not mark a rising or falling period.
- R3: minLow holds the smallest length, in clock cycles of the synchronized line, of any complete accepted low run since the last start. The run that is in progress at the start is not complete.
- R4: minHigh holds the smallest length of any complete accepted high run since the last start, counted in the same way.
- R5: edgeCount increments by one for each accepted edge of either polarity and saturates at 1023.
- R6: risePeriod holds the cycle count between the last two accepted rising edges, and fallPeriod the cycle count between the last two accepted falling edges. A period needs two such edges after the start; until then the output stays 0.
- R7: A start happens in the cycle where clearIn is 1, or where measEn is 1 after having been 0 in the previous cycle. It sets minLow and minHigh to all ones and edgeCount, risePeriod and fallPeriod to 0.
- R8: Every length and period counter saturates at 2^CNT_W-1. A run longer than that is reported as 2^CNT_W-1.
- R9: After reset, minLow and minHigh are all ones, the other outputs are 0, and the synchronized line reads as idle high.
- R10: rxIn passes through a two-flop synchronizer before any edge detection, so a level held for N clock samples on rxIn gives a run of N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxIn | input | 1 | Raw serial receive line |
| measEn | input | 1 | Measurement on when 1 |
| glitchWidth | input | 8 | Shortest accepted run, in cycles |
| clearIn | input | 1 | Restart measurement |
| minLow | output | 20 | Shortest low run |
| minHigh | output | 20 | Shortest high run |
| edgeCount | output | 10 | Accepted edges, saturating |
| risePeriod | output | 20 | Last rising-to-rising spacing |
| fallPeriod | output | 20 | Last falling-to-falling spacing |

## Verification
The assertions check several properties on every cycle. The minima never grow except at a start, and a start leaves the fixed initial values. The edge counter only steps by one and stays put at 1023. With measurement off, every output is frozen. Whether a given run is accepted or rejected, and which exact widths and periods result, depends on the pulse trains the bench applies. Those values are shown by a cycle-level reference model compared against both a full-width and a narrow-counter instance. The hand-computed checks then cover pulse trains, glitches, edge saturation and width saturation.

// File: rtl/baud_meter_pkg.sv
package baud_meter_pkg;
  // Strobes from control to datapath, valid for the current cycle
  typedef struct packed {
    logic init;      // start of a fresh measurement
    logic run;       // measuring, no start this cycle
    logic anyEdge;   // line changed level while measuring
    logic edgeOk;    // edge ends a run at least glitchWidth long
    logic lowDone;   // accepted end of a complete low run
    logic highDone;  // accepted end of a complete high run
    logic riseEdge;  // accepted rising edge
    logic riseLoad;  // accepted rising edge with a previous one seen
    logic fallEdge;  // accepted falling edge
    logic fallLoad;  // accepted falling edge with a previous one seen
  } meas_strobe_t;
endpackage

// File: rtl/baud_rx_sync.sv
module baud_rx_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rxIn,
  output logic rxLvl,
  output logic rxPrev
);
  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] pipe;

  // synchronizer stages plus one history flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '1;
    else       pipe <= {pipe[PIPE_W-2:0], rxIn};
  end

  assign rxLvl  = pipe[SYNC_STAGES-1];
  assign rxPrev = pipe[SYNC_STAGES];
endmodule

// File: rtl/baud_ctrl.sv
module baud_ctrl
  import baud_meter_pkg::*;
#(
  parameter int CNT_W    = 20,
  parameter int GLITCH_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                measEn,
  input  logic                clearIn,
  input  logic [GLITCH_W-1:0] glitchWidth,
  input  logic                rxLvl,
  input  logic                rxPrev,
  input  logic [CNT_W-1:0]    runLen,
  output meas_strobe_t        strb
);
  localparam int CMP_W = (CNT_W > GLITCH_W) ? CNT_W : GLITCH_W;

  logic enPrev;
  logic haveEdge;
  logic haveRise;
  logic haveFall;
  logic widthOk;
  logic [CMP_W-1:0] runExt;
  logic [CMP_W-1:0] glitchExt;

  assign runExt    = CMP_W'(runLen);
  assign glitchExt = CMP_W'(glitchWidth);
  assign widthOk   = runExt >= glitchExt;

  always_comb begin
    strb          = '0;
    strb.init     = clearIn | (measEn & ~enPrev);
    strb.run      = measEn & ~strb.init;
    strb.anyEdge  = strb.run & (rxLvl ^ rxPrev);
    strb.edgeOk   = strb.anyEdge & widthOk;
    strb.lowDone  = strb.edgeOk & haveEdge & ~rxPrev;
    strb.highDone = strb.edgeOk & haveEdge & rxPrev;
    strb.riseEdge = strb.edgeOk & rxLvl;
    strb.fallEdge = strb.edgeOk & ~rxLvl;
    strb.riseLoad = strb.riseEdge & haveRise;
    strb.fallLoad = strb.fallEdge & haveFall;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPrev   <= 1'b0;
      haveEdge <= 1'b0;
      haveRise <= 1'b0;
      haveFall <= 1'b0;
    end else begin
      enPrev <= measEn;
      if (strb.init) begin
        haveEdge <= 1'b0;
        haveRise <= 1'b0;
        haveFall <= 1'b0;
      end else begin
        if (strb.anyEdge)  haveEdge <= 1'b1;
        if (strb.riseEdge) haveRise <= 1'b1;
        if (strb.fallEdge) haveFall <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/baud_datapath.sv
module baud_datapath
  import baud_meter_pkg::*;
#(
  parameter int CNT_W  = 20,
  parameter int EDGE_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  meas_strobe_t      strb,
  output logic [CNT_W-1:0]  runLen,
  output logic [CNT_W-1:0]  minLow,
  output logic [CNT_W-1:0]  minHigh,
  output logic [EDGE_W-1:0] edgeCount,
  output logic [CNT_W-1:0]  risePeriod,
  output logic [CNT_W-1:0]  fallPeriod
);
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
  localparam logic [EDGE_W-1:0] EDGE_MAX = '1;
  localparam int N_IVL = 3;  // 0: current run, 1: since rise, 2: since fall

  logic [CNT_W-1:0] ivl [N_IVL];
  logic [N_IVL-1:0] restart;
  logic [CNT_W-1:0] minReg [2];  // 0: low, 1: high
  logic [1:0]       minDone;
  logic [CNT_W-1:0] perReg [2];  // 0: rise, 1: fall
  logic [1:0]       perLoad;
  logic [EDGE_W-1:0] edgeReg;

  assign restart = {strb.fallEdge, strb.riseEdge, strb.anyEdge};
  assign minDone = {strb.highDone, strb.lowDone};
  assign perLoad = {strb.fallLoad, strb.riseLoad};

  // saturating interval counters
  for (genvar i = 0; i < N_IVL; i++) begin : g_ivl
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   ivl[i] <= '0;
      else if (strb.init)          ivl[i] <= '0;
      else if (strb.run) begin
        if (restart[i])            ivl[i] <= CNT_W'(1);
        else if (ivl[i] != CNT_MAX) ivl[i] <= ivl[i] + 1'b1;
      end
    end
  end

  // running minima of complete runs, per polarity
  for (genvar p = 0; p < 2; p++) begin : g_min
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                 minReg[p] <= CNT_MAX;
      else if (strb.init)                        minReg[p] <= CNT_MAX;
      else if (minDone[p] && ivl[0] < minReg[p]) minReg[p] <= ivl[0];
    end
  end

  // same-polarity edge spacing
  for (genvar p = 0; p < 2; p++) begin : g_per
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           perReg[p] <= '0;
      else if (strb.init)  perReg[p] <= '0;
      else if (perLoad[p]) perReg[p] <= ivl[p+1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                edgeReg <= '0;
    else if (strb.init)                       edgeReg <= '0;
    else if (strb.edgeOk && edgeReg != EDGE_MAX) edgeReg <= edgeReg + 1'b1;
  end

  assign runLen     = ivl[0];
  assign minLow     = minReg[0];
  assign minHigh    = minReg[1];
  assign risePeriod = perReg[0];
  assign fallPeriod = perReg[1];
  assign edgeCount  = edgeReg;
endmodule

// File: rtl/baud_meter.sv
module baud_meter
  import baud_meter_pkg::*;
#(
  parameter int CNT_W       = 20,
  parameter int EDGE_W      = 10,
  parameter int GLITCH_W    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxIn,
  input  logic                measEn,
  input  logic [GLITCH_W-1:0] glitchWidth,
  input  logic                clearIn,
  output logic [CNT_W-1:0]    minLow,
  output logic [CNT_W-1:0]    minHigh,
  output logic [EDGE_W-1:0]   edgeCount,
  output logic [CNT_W-1:0]    risePeriod,
  output logic [CNT_W-1:0]    fallPeriod
);
  logic         rxLvl;
  logic         rxPrev;
  logic [CNT_W-1:0] runLen;
  meas_strobe_t ctrlStrb;
  logic         strbInit;

  assign strbInit = ctrlStrb.init;

  baud_rx_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .rxLvl(rxLvl), .rxPrev(rxPrev)
  );

  baud_ctrl #(.CNT_W(CNT_W), .GLITCH_W(GLITCH_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .measEn(measEn), .clearIn(clearIn),
    .glitchWidth(glitchWidth), .rxLvl(rxLvl), .rxPrev(rxPrev),
    .runLen(runLen), .strb(ctrlStrb)
  );

  baud_datapath #(.CNT_W(CNT_W), .EDGE_W(EDGE_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(ctrlStrb), .runLen(runLen),
    .minLow(minLow), .minHigh(minHigh), .edgeCount(edgeCount),
    .risePeriod(risePeriod), .fallPeriod(fallPeriod)
  );
endmodule

// File: rtl/baud_meter_chk.sv
module baud_meter_chk #(
  parameter int CNT_W  = 20,
  parameter int EDGE_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              measEn,
  input logic              clearIn,
  input logic              strbInit,
  input logic [CNT_W-1:0]  minLow,
  input logic [CNT_W-1:0]  minHigh,
  input logic [EDGE_W-1:0] edgeCount,
  input logic [CNT_W-1:0]  risePeriod,
  input logic [CNT_W-1:0]  fallPeriod
);
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
  localparam logic [EDGE_W-1:0] EDGE_MAX = '1;

  a_r1_frozen_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (!measEn && !clearIn) |=> ($stable(minLow) && $stable(minHigh) &&
      $stable(edgeCount) && $stable(risePeriod) && $stable(fallPeriod)));

  a_r3_low_min_never_grows: assert property (@(posedge clk) disable iff (!rstN)
    !strbInit |=> minLow <= $past(minLow));

  a_r4_high_min_never_grows: assert property (@(posedge clk) disable iff (!rstN)
    !strbInit |=> minHigh <= $past(minHigh));

  a_r5_edge_single_step: assert property (@(posedge clk) disable iff (!rstN)
    !strbInit |=> (edgeCount == $past(edgeCount)) ||
                  (edgeCount == $past(edgeCount) + 1'b1));

  a_r5_edge_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (edgeCount == EDGE_MAX && !strbInit) |=> edgeCount == EDGE_MAX);

  a_r7_start_values: assert property (@(posedge clk) disable iff (!rstN)
    strbInit |=> (minLow == CNT_MAX && minHigh == CNT_MAX && edgeCount == '0 &&
                  risePeriod == '0 && fallPeriod == '0));
endmodule

bind baud_meter baud_meter_chk #(.CNT_W(CNT_W), .EDGE_W(EDGE_W)) chk_i (
  .clk(clk), .rstN(rstN), .measEn(measEn), .clearIn(clearIn),
  .strbInit(strbInit), .minLow(minLow), .minHigh(minHigh),
  .edgeCount(edgeCount), .risePeriod(risePeriod), .fallPeriod(fallPeriod)
);

// File: tb/baud_meter_tb_top.sv
`timescale 1ns/1ps
module baud_meter_tb_top;
  localparam int SMALL_W = 8;

  typedef struct {
    int s1, s2, prev, enPrev;
    int runLen, riseCnt, fallCnt;
    int haveEdge, haveRise, haveFall;
    int minLow, minHigh, edges, riseP, fallP;
  } mdl_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxIn = 1'b1;
  logic measEn = 1'b0;
  logic clearIn = 1'b0;
  logic [7:0] glitchWidth = 8'd0;

  logic [19:0] minLowA, minHighA, riseA, fallA;
  logic [9:0]  edgeA;
  logic [SMALL_W-1:0] minLowB, minHighB, riseB, fallB;
  logic [9:0]  edgeB;

  int compared = 0;
  int mismatched = 0;
  bit started = 0;
  mdl_t mA, mB;

  always #10 clk = ~clk;

  baud_meter dut_i (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .measEn(measEn),
    .glitchWidth(glitchWidth), .clearIn(clearIn),
    .minLow(minLowA), .minHigh(minHighA), .edgeCount(edgeA),
    .risePeriod(riseA), .fallPeriod(fallA)
  );

  baud_meter #(.CNT_W(SMALL_W)) dut_small (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .measEn(measEn),
    .glitchWidth(glitchWidth), .clearIn(clearIn),
    .minLow(minLowB), .minHigh(minHighB), .edgeCount(edgeB),
    .risePeriod(riseB), .fallPeriod(fallB)
  );

  function automatic mdl_t resetM(int maxv);
    mdl_t r;
    r.s1 = 1; r.s2 = 1; r.prev = 1; r.enPrev = 0;
    r.runLen = 0; r.riseCnt = 0; r.fallCnt = 0;
    r.haveEdge = 0; r.haveRise = 0; r.haveFall = 0;
    r.minLow = maxv; r.minHigh = maxv; r.edges = 0; r.riseP = 0; r.fallP = 0;
    return r;
  endfunction

  function automatic int satInc(int v, int maxv);
    return (v >= maxv) ? maxv : v + 1;
  endfunction

  // behavioural reference: one clock of the measurement rules
  function automatic mdl_t stepM(mdl_t m, int rx, int en, int gw, int clr, int maxv);
    mdl_t n = m;
    bit edgeNow = (m.s2 != m.prev);
    bit startNow = (clr != 0) || (en != 0 && m.enPrev == 0);
    if (startNow) begin
      n.runLen = 0; n.riseCnt = 0; n.fallCnt = 0;
      n.haveEdge = 0; n.haveRise = 0; n.haveFall = 0;
      n.minLow = maxv; n.minHigh = maxv; n.edges = 0; n.riseP = 0; n.fallP = 0;
    end else if (en != 0) begin
      bit ok = edgeNow && (m.runLen >= gw);
      if (ok) begin
        if (m.edges < 1023) n.edges = m.edges + 1;
        if (m.haveEdge != 0) begin
          if (m.prev == 0 && m.runLen < m.minLow)  n.minLow = m.runLen;
          if (m.prev == 1 && m.runLen < m.minHigh) n.minHigh = m.runLen;
        end
      end
      if (edgeNow) n.haveEdge = 1;
      n.runLen = edgeNow ? 1 : satInc(m.runLen, maxv);
      if (ok && m.s2 == 1) begin
        if (m.haveRise != 0) n.riseP = m.riseCnt;
        n.haveRise = 1; n.riseCnt = 1;
      end else n.riseCnt = satInc(m.riseCnt, maxv);
      if (ok && m.s2 == 0) begin
        if (m.haveFall != 0) n.fallP = m.fallCnt;
        n.haveFall = 1; n.fallCnt = 1;
      end else n.fallCnt = satInc(m.fallCnt, maxv);
    end
    n.prev = m.s2; n.s2 = m.s1; n.s1 = rx; n.enPrev = en;
    return n;
  endfunction

  initial begin
    mA = resetM(20'hFFFFF);
    mB = resetM((1 << SMALL_W) - 1);
  end

  always @(posedge clk) begin
    if (!rstN) begin
      mA = resetM(20'hFFFFF);
      mB = resetM((1 << SMALL_W) - 1);
    end else begin
      mA = stepM(mA, int'(rxIn), int'(measEn), int'(glitchWidth), int'(clearIn), 20'hFFFFF);
      mB = stepM(mB, int'(rxIn), int'(measEn), int'(glitchWidth), int'(clearIn), (1 << SMALL_W) - 1);
    end
  end

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN && started) begin
      chk("R3 minLow", int'(minLowA), mA.minLow);
      chk("R4 minHigh", int'(minHighA), mA.minHigh);
      chk("R5 edgeCount", int'(edgeA), mA.edges);
      chk("R6 risePeriod", int'(riseA), mA.riseP);
      chk("R6 fallPeriod", int'(fallA), mA.fallP);
      chk("R8 narrow minLow", int'(minLowB), mB.minLow);
      chk("R8 narrow minHigh", int'(minHighB), mB.minHigh);
      chk("R8 narrow edgeCount", int'(edgeB), mB.edges);
      chk("R8 narrow risePeriod", int'(riseB), mB.riseP);
      chk("R8 narrow fallPeriod", int'(fallB), mB.fallP);
    end
  end

  task automatic hold(logic lvl, int n);
    rxIn = lvl;
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulseClear();
    clearIn = 1'b1;
    @(posedge clk); #2;
    clearIn = 1'b0;
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rstN = 1'b1;
    started = 1;
    @(posedge clk); #2;
    // R9: reset state
    chk("R9 reset minLow", int'(minLowA), 20'hFFFFF);
    chk("R9 reset edgeCount", int'(edgeA), 0);
    chk("R9 reset risePeriod", int'(riseA), 0);

    // R3 R4 R6 R10: clean pulse train
    glitchWidth = 8'd2;
    measEn = 1'b1;
    hold(1'b1, 8);
    hold(1'b0, 8); hold(1'b1, 6); hold(1'b0, 12); hold(1'b1, 9);
    hold(1'b1, 20);
    chk("R3 shortest low", int'(minLowA), 8);
    chk("R4 shortest high", int'(minHighA), 6);
    chk("R5 edges in train", int'(edgeA), 4);
    chk("R6 rise spacing", int'(riseA), 18);
    chk("R6 fall spacing", int'(fallA), 14);

    // R2 R7: clear, then a short low glitch
    glitchWidth = 8'd4;
    pulseClear();
    chk("R7 clear minHigh", int'(minHighA), 20'hFFFFF);
    chk("R7 clear edgeCount", int'(edgeA), 0);
    hold(1'b1, 8);
    hold(1'b0, 10); hold(1'b1, 10); hold(1'b0, 2); hold(1'b1, 10); hold(1'b0, 10);
    hold(1'b1, 20);
    chk("R2 glitch not a minimum", int'(minLowA), 10);
    chk("R2 glitch edge not counted", int'(edgeA), 5);

    // R1: disabled, line activity has no effect
    measEn = 1'b0;
    hold(1'b1, 3);
    for (int k = 0; k < 6; k++) hold(k[0], 5);
    hold(1'b1, 10);
    chk("R1 hold minLow", int'(minLowA), 10);
    chk("R1 hold edgeCount", int'(edgeA), 5);
    chk("R1 hold minHigh", int'(minHighA), 10);

    // R5: edge count saturation
    glitchWidth = 8'd1;
    measEn = 1'b1;
    hold(1'b1, 8);
    for (int k = 0; k < 1100; k++) hold(~k[0], 3);
    hold(1'b1, 10);
    chk("R5 edge saturation", int'(edgeA), 1023);
    chk("R6 rise spacing toggles", int'(riseA), 6);

    // R8: width saturation on the narrow instance
    pulseClear();
    hold(1'b1, 8);
    hold(1'b0, 5); hold(1'b1, 300); hold(1'b0, 5);
    hold(1'b1, 20);
    chk("R4 long high wide", int'(minHighA), 300);
    chk("R8 long high narrow", int'(minHighB), 255);
    chk("R3 low after saturation", int'(minLowB), 5);

    finishRun();
  end
endmodule